// File: doc/BRIEF.md
# GPIO Bank Controller with Masked-Write Aliases

This block controls one bank of 32 general-purpose pins, grouped into four ports of eight pins. Each port has three writable byte-wide registers: a configuration enable (CFG), an output enable (DIR) and an output value (DOUT). It also has one read-only register (DIN) that shows the synchronised pad level. A pin drives its pad only when both its CFG bit and its DIR bit are set. A pin whose DIR bit is clear behaves as an input.

Software reaches the registers over a simple 32-bit bus with separate read and write strobes. The three writable registers also appear a second time, at a parameterised offset above the plain map. A write to that second copy carries a per-pin enable mask next to the new values. A driver can therefore flip one pin without first reading the port, so two agents that touch different pins of the same port cannot undo each other's updates.

Pad inputs pass through a two-stage synchroniser before DIN shows them. Read data is registered and appears one cycle after the read strobe.

Top module: `gpb_bank`

## Requirements
- R1: While reset is active and directly after it, every CFG, DIR and DOUT bit is 0, so `pad_oe` and `pad_out` are all 0 and reads of those registers return 0.
- R2: A write to a plain address replaces all 8 bits of the selected port register with `bus_wdata[7:0]`, and no other register changes. Plain addresses are CFG at 0x00, DIR at 0x10 and DOUT at 0x20, plus 4×port (port 0..3 holds pins 8×port..8×port+7, bit k = pin 8×port+k).
- R3: A write to the same offset plus `UPPER_OFS` is a masked write. Pin k of the port takes `bus_wdata[k]` only when `bus_wdata[8+k]` is 1. Every other pin keeps its value.
- R4: `pad_oe[i]` is 1 exactly when CFG and DIR bit i are both 1. `pad_out[i]` equals DOUT bit i.
- R5: A read of DIN at 0x30+4×port returns, in bits 7:0, the level that `pad_in` had before the two most recent clock edges.
- R6: Writes have no effect when they target DIN (at 0x30+4×port or at `UPPER_OFS`+0x30+4×port) or any address outside the two 64-byte windows.
- R7: `bus_rdata` is updated on the edge that samples `bus_rd` and then holds its value. It is zero-extended from the 8-bit register value for both plain and masked addresses, and is 0 for an unmapped address or for the masked copy of DIN.
- R8: When a read and a write reach the same register in one cycle, the read returns the value from before the write, and the next read returns the new value.
- R9: A masked write whose mask bits 15:8 are all 0 leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data (mask in 15:8 for masked writes) |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels from the pins |
| pad_out | output | 32 | Values driven to the pins |
| pad_oe | output | 32 | Per-pin drive enable |

## Verification
A read and a write can reach the same register in the same cycle. The read has to return the value from before the write, while the register and the pad outputs take the written value on that same edge. The bench provokes this by raising both strobes with one address, on a plain DOUT address and on a masked CFG address. Its behavioural model computes the read result from its state before the update, then checks `bus_rdata`, `pad_out` and `pad_oe` after that edge. It then reads again to confirm the new value. A change on the pads that arrives during a DIN read is checked the same way against the model's two-entry synchroniser queue.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int NUM_PORTS  = 4;
  localparam int PORT_BITS  = 8;
  localparam int BANK_PINS  = NUM_PORTS * PORT_BITS;
  localparam int NUM_RW_GRP = 3;

  typedef enum logic [1:0] {
    GRP_CFG  = 2'd0,
    GRP_DIR  = 2'd1,
    GRP_DOUT = 2'd2,
    GRP_DIN  = 2'd3
  } grp_e;

  typedef struct packed {
    logic       plain;
    logic       masked;
    grp_e       grp;
    logic [1:0] port;
  } dec_t;

  function automatic logic [PORT_BITS-1:0] masked_merge(
      input logic [PORT_BITS-1:0] old_v,
      input logic [PORT_BITS-1:0] new_v,
      input logic [PORT_BITS-1:0] sel);
    return (old_v & ~sel) | (new_v & sel);
  endfunction

  function automatic logic [PORT_BITS-1:0] touch_set(
      input logic                 we,
      input logic                 masked,
      input logic [PORT_BITS-1:0] sel);
    if (!we)         return '0;
    else if (masked) return sel;
    else             return '1;
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpb_addr_dec.sv
module gpb_addr_dec
  import gpb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 'h80
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] UP_ADDR = ADDR_W'(UPPER_OFS);

  logic [ADDR_W-7:0] blk;
  logic              unused_lo;

  assign blk       = addr[ADDR_W-1:6];
  assign unused_lo = ^addr[1:0];

  always_comb begin
    dec.plain  = (blk == '0);
    dec.masked = (blk == UP_ADDR[ADDR_W-1:6]);
    dec.grp    = grp_e'(addr[5:4]);
    dec.port   = addr[3:2];
  end
endmodule

// File: rtl/gpb_field.sv
module gpb_field
  import gpb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 masked,
  input  logic [15:0]          wbits,
  output logic [PORT_BITS-1:0] q,
  output logic [PORT_BITS-1:0] touch
);
  logic [PORT_BITS-1:0] nxt;

  assign nxt   = masked ? masked_merge(q, wbits[7:0], wbits[15:8]) : wbits[7:0];
  assign touch = touch_set(we, masked, wbits[15:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= nxt;
  end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
  import gpb_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int UPPER_OFS   = 'h80,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe
);
  dec_t                 dec;
  logic                 wr_hit;
  logic                 rd_hit;
  logic [PORT_BITS-1:0] fld_q     [NUM_RW_GRP][NUM_PORTS];
  logic [PORT_BITS-1:0] fld_touch [NUM_RW_GRP][NUM_PORTS];
  logic [BANK_PINS-1:0] cfg_vec, dir_vec, dout_vec, din_vec;
  logic [BANK_PINS-1:0] cfg_touch, dir_touch, dout_touch;
  logic [PORT_BITS-1:0] rd_byte;
  logic                 unused_hi;

  assign unused_hi = ^bus_wdata[31:16];

  gpb_addr_dec #(.ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS)) i_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_hit = (dec.plain || dec.masked) && (dec.grp != GRP_DIN);
  assign rd_hit = dec.plain || (dec.masked && dec.grp != GRP_DIN);

  for (genvar g = 0; g < NUM_RW_GRP; g++) begin : g_grp
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel;
      assign sel = bus_wr && wr_hit && (dec.grp == grp_e'(g)) && (dec.port == 2'(p));
      gpb_field i_fld (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sel),
        .masked (dec.masked),
        .wbits  (bus_wdata[15:0]),
        .q      (fld_q[g][p]),
        .touch  (fld_touch[g][p])
      );
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_vec
    assign cfg_vec[p*PORT_BITS +: PORT_BITS]    = fld_q[GRP_CFG][p];
    assign dir_vec[p*PORT_BITS +: PORT_BITS]    = fld_q[GRP_DIR][p];
    assign dout_vec[p*PORT_BITS +: PORT_BITS]   = fld_q[GRP_DOUT][p];
    assign cfg_touch[p*PORT_BITS +: PORT_BITS]  = fld_touch[GRP_CFG][p];
    assign dir_touch[p*PORT_BITS +: PORT_BITS]  = fld_touch[GRP_DIR][p];
    assign dout_touch[p*PORT_BITS +: PORT_BITS] = fld_touch[GRP_DOUT][p];
  end

  gpb_sync #(.WIDTH(BANK_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .d   (pad_in),
    .q   (din_vec)
  );

  always_comb begin
    rd_byte = '0;
    if (rd_hit) begin
      unique case (dec.grp)
        GRP_CFG:  rd_byte = fld_q[GRP_CFG][dec.port];
        GRP_DIR:  rd_byte = fld_q[GRP_DIR][dec.port];
        GRP_DOUT: rd_byte = fld_q[GRP_DOUT][dec.port];
        default:  rd_byte = din_vec[dec.port*PORT_BITS +: PORT_BITS];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {24'h0, rd_byte};
  end

  assign pad_oe  = cfg_vec & dir_vec;
  assign pad_out = dout_vec;
endmodule

// File: rtl/gpb_bank_chk.sv
module gpb_bank_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pad_in,
  input logic        wr_hit,
  input logic        rd_hit,
  input logic        is_masked,
  input logic [31:0] cfg_vec,
  input logic [31:0] dir_vec,
  input logic [31:0] dout_vec,
  input logic [31:0] din_vec,
  input logic [31:0] cfg_touch,
  input logic [31:0] dir_touch,
  input logic [31:0] dout_touch
);
  // R2 / R3: a register bit may only change where the decoder allowed it
  p_change_within_touch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((cfg_vec ^ $past(cfg_vec)) & ~$past(cfg_touch)) == 0) &&
    (((dir_vec ^ $past(dir_vec)) & ~$past(dir_touch)) == 0) &&
    (((dout_vec ^ $past(dout_vec)) & ~$past(dout_touch)) == 0));

  p_zero_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_masked && bus_wdata[15:8] == 8'h00) |=>
      ($stable(cfg_vec) && $stable(dir_vec) && $stable(dout_vec)));

  p_miss_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_hit) |=>
      ($stable(cfg_vec) && $stable(dir_vec) && $stable(dout_vec)));

  p_unmapped_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_hit) |=> (bus_rdata == 32'h0));

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> $stable(bus_rdata));

  if (SYNC_STAGES == 2) begin : g_sync2
    p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      din_vec == $past(pad_in, 2));
  end
endmodule

bind gpb_bank gpb_bank_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pad_in     (pad_in),
  .wr_hit     (wr_hit),
  .rd_hit     (rd_hit),
  .is_masked  (dec.masked),
  .cfg_vec    (cfg_vec),
  .dir_vec    (dir_vec),
  .dout_vec   (dout_vec),
  .din_vec    (din_vec),
  .cfg_touch  (cfg_touch),
  .dir_touch  (dir_touch),
  .dout_touch (dout_touch)
);

// File: tb/test_gpb_bank.sv
`timescale 1ns/1ps
module test_gpb_bank;
  localparam int AW = 12;
  localparam int UP = 'h80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [31:0]   pad_in = '0;
  logic [31:0]   pad_out, pad_oe;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;

  // reference state: per group, per port bytes; synchroniser as a queue
  logic [7:0]  m_reg [3][4];
  logic [31:0] m_sync [$];

  always #2 clk = ~clk;

  gpb_bank #(.ADDR_W(AW), .UPPER_OFS(UP)) i_gpb_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] m_vec(input int g);
    logic [31:0] v;
    for (int p = 0; p < 4; p++) v[p*8 +: 8] = m_reg[g][p];
    return v;
  endfunction

  function automatic logic [31:0] m_read(input int a);
    int off, g, p;
    bit pl, mk;
    pl  = (a < 'h40);
    mk  = (a >= UP) && (a < UP + 'h40);
    off = a % 'h40;
    g   = off / 16;
    p   = (off / 4) % 4;
    if (!(pl || mk)) return 0;
    if (g == 3) return pl ? {24'h0, m_sync[0][p*8 +: 8]} : 32'h0;
    return {24'h0, m_reg[g][p]};
  endfunction

  task automatic m_write(input int a, input logic [31:0] d);
    int off, g, p;
    bit pl, mk;
    pl  = (a < 'h40);
    mk  = (a >= UP) && (a < UP + 'h40);
    off = a % 'h40;
    g   = off / 16;
    p   = (off / 4) % 4;
    if (!(pl || mk) || g == 3) return;
    if (pl) m_reg[g][p] = d[7:0];
    else for (int k = 0; k < 8; k++) if (d[8+k]) m_reg[g][p][k] = d[k];
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: drive, let the edge happen, update model, compare
  task automatic step(input logic w, input logic r, input int a,
                      input logic [31:0] d, input logic [31:0] pin, input string tag);
    logic [31:0] exp_rd;
    bus_wr = w; bus_rd = r; bus_addr = AW'(a); bus_wdata = d; pad_in = pin;
    @(posedge clk);
    exp_rd = m_read(a);
    if (w) m_write(a, d);
    void'(m_sync.pop_front());
    m_sync.push_back(pin);
    #1;
    check(tag, "pad_out", pad_out, m_vec(2));
    check(tag, "pad_oe", pad_oe, m_vec(0) & m_vec(1));
    if (r) check(tag, "rdata", bus_rdata, exp_rd);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, 1'b1, a, 32'h0, pad_in, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, pad_in, tag);
  endtask

  initial begin
    for (int g = 0; g < 3; g++) for (int p = 0; p < 4; p++) m_reg[g][p] = 8'h00;
    m_sync.push_back(32'h0); m_sync.push_back(32'h0);
    repeat (4) @(posedge clk);
    #1;
    // R1: outputs idle during reset
    check("R1", "pad_oe in reset", pad_oe, 32'h0);
    check("R1", "pad_out in reset", pad_out, 32'h0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      rd('h00 + 4*p, "R1");
      rd('h10 + 4*p, "R1");
      rd('h20 + 4*p, "R1");
    end
    // R2: plain writes, whole port replaced
    wr('h04, 32'hFFFF_00A5, "R2");
    wr('h14, 32'h0000_000F, "R2");
    wr('h24, 32'h0000_003C, "R2");
    wr('h2C, 32'h0000_00C3, "R2");
    rd('h04, "R2"); rd('h14, "R2"); rd('h24, "R2"); rd('h28, "R2");
    // R4: enable both bits for port 0 and check gating
    wr('h00, 32'h0000_00F0, "R4");
    wr('h10, 32'h0000_0033, "R4");
    wr('h20, 32'h0000_0055, "R4");
    // R3: masked writes on each group
    wr(UP + 'h24, 32'h0000_8101, "R3");
    wr(UP + 'h04, 32'h0000_0F0A, "R3");
    wr(UP + 'h1C, 32'h0000_FFAA, "R3");
    rd(UP + 'h24, "R3"); rd('h24, "R3"); rd(UP + 'h04, "R7"); rd(UP + 'h1C, "R7");
    // R9: empty mask
    wr(UP + 'h24, 32'h0000_00FF, "R9");
    wr(UP + 'h00, 32'h0000_0000, "R9");
    rd('h24, "R9"); rd('h00, "R9");
    // R6: writes to DIN and outside the windows
    wr('h34, 32'h0000_00FF, "R6");
    wr(UP + 'h34, 32'h0000_FFFF, "R6");
    wr('h40, 32'h0000_00FF, "R6");
    wr('h200, 32'h0000_FFFF, "R6");
    wr(UP + 'h40, 32'h0000_FFFF, "R6");
    rd('h04, "R6"); rd('h14, "R6"); rd('h24, "R6");
    // R7: unmapped reads and masked DIN read are 0
    rd('h40, "R7"); rd(UP + 'h30, "R7"); rd('h7FC, "R7");
    // R5: pad change seen after two edges
    step(1'b0, 1'b0, 0, 32'h0, 32'hDEAD_BEEF, "R5");
    rd('h30, "R5"); rd('h34, "R5"); rd('h38, "R5"); rd('h3C, "R5");
    step(1'b0, 1'b1, 'h38, 32'h0, 32'h1234_5678, "R5");
    rd('h38, "R5"); rd('h3C, "R5"); rd('h30, "R5");
    // R8: read and write same register in one cycle
    step(1'b1, 1'b1, 'h24, 32'h0000_0077, pad_in, "R8");
    rd('h24, "R8");
    step(1'b1, 1'b1, UP + 'h0C, 32'h0000_3C14, pad_in, "R8");
    rd('h0C, "R8");
    // R2: walking patterns over every register
    for (int g = 0; g < 3; g++)
      for (int p = 0; p < 4; p++) begin
        wr(g*16 + 4*p, 32'h0000_0000 | ((g*4 + p) * 8'h17), "R2");
        rd(g*16 + 4*p, "R2");
      end
    // R1: reset again clears everything
    rst_n = 1'b0;
    #1;
    for (int g = 0; g < 3; g++) for (int p = 0; p < 4; p++) m_reg[g][p] = 8'h00;
    check("R1", "pad_oe after reset", pad_oe, 32'h0);
    check("R1", "pad_out after reset", pad_out, 32'h0);
    check("R1", "rdata after reset", bus_rdata, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd('h20, "R1"); rd('h10, "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog run did not finish got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule